// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is a byte-oriented asynchronous serial transmitter and receiver that sits behind a small register window. Software picks the character shape through a frame word: five to eight data bits, an optional parity bit of either sense, one or two stop bits, and a break override that holds the line low. It picks the bit rate through a divisor. A byte written to the data offset is sent least significant bit first. A received byte is read back from the same offset, with its error marks above the data.

Each direction has a one-entry holding buffer by default. Setting the buffer-enable field in the frame word deepens both directions to a small queue. Three modem inputs (clear-to-send, data-set-ready and carrier-detect) are synchronised and shown in the flag word. Any change on them raises a status event. Receive, transmit and modem events are latched in a status word, gated by a mask and combined into one interrupt line. A write of ones to the clear offset removes events.

Top module: `uart_core`

## Requirements
- R1: After reset txd_o is 1, irq_o is 0, the flag word reads 0x10 (only receive-empty set) and the frame, divisor, mask and status words read 0.
- R2: A transmitted frame is a 0 start bit, the data bits least significant first, the parity bit if enabled, then one stop bit (two when frame bit 3 is set). Each bit lasts 16*(divisor+1) clock cycles.
- R3: Frame bits 6:5 hold the word length minus five (00 gives 5 bits, 11 gives 8). Data bits above the length are not sent, and they read back as 0 on receive.
- R4: Frame bit 1 enables parity. When frame bit 2 is 1 the parity makes the count of ones in data plus parity even; when it is 0, odd.
- R5: While frame bit 0 is set, txd_o is held at 0. When the bit is cleared, txd_o returns to idle 1.
- R6: A data read (offset 0x00) returns the byte in bits 7:0 and pops it. Bit 8 marks a stop bit received as 0 and bit 9 marks a parity mismatch.
- R7: When frame bit 4 is 0, each direction holds one entry. A frame that arrives while the receive entry is full is dropped, and bit 10 is set on the next data read. When frame bit 4 is 1, FIFO_DEPTH received bytes are kept in order.
- R8: Flag word (offset 0x10) bits: 0 clear-to-send, 1 data-set-ready, 2 carrier-detect, 3 busy (from a data write until the last stop bit of that byte ends), 4 receive empty, 5 transmit full.
- R9: Status word (offset 0x14) bit 0 is set on each accepted received byte. Bit 1 is set when a frame ends with no byte waiting. Bit 2 is set on any modem input change. irq_o is 1 when a status bit and its mask bit (offset 0x18) are both 1. Writing ones to offset 0x1C clears the matching status bits.
- R10: While port bit 0 (offset 0x0C) is 0, no transmission starts and the receiver ignores the line. Setting the bit starts the waiting byte.
- R11: The frame word (0x04), divisor (0x08), port word (0x0C, bits 1:0) and mask (0x18) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Masked interrupt |
| txd_o | output | 1 | Serial output |
| rxd_i | input | 1 | Serial input |
| cts_i | input | 1 | Clear-to-send input |
| dsr_i | input | 1 | Data-set-ready input |
| dcd_i | input | 1 | Carrier-detect input |

## Verification
Random bytes are sent in loopback under random word length, parity sense, parity enable and stop count. Each run compares both the sampled line bits and the returned byte, which separates an error in bit order, length masking or parity polarity from an error in the receiver. Directed frames with a flipped parity bit or a low stop bit show whether each error mark lands in its own bit. Back-to-back frames with the buffer at one entry and then deepened show the difference between overrun marking and in-order queueing. Modem toggles, masking and clear writes show whether status and interrupt are kept apart, and a disabled port is held against a pending byte and an incoming frame.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam logic [4:0] OFS_DATA  = 5'h00;
  localparam logic [4:0] OFS_FRAME = 5'h04;
  localparam logic [4:0] OFS_DIV   = 5'h08;
  localparam logic [4:0] OFS_PORT  = 5'h0C;
  localparam logic [4:0] OFS_FLAG  = 5'h10;
  localparam logic [4:0] OFS_ISTAT = 5'h14;
  localparam logic [4:0] OFS_IMASK = 5'h18;
  localparam logic [4:0] OFS_ICLR  = 5'h1C;

  typedef struct packed {
    logic [1:0] wlen;
    logic       fifo_en;
    logic       stop2;
    logic       even;
    logic       par_en;
    logic       brk;
  } frame_cfg_t;

  localparam int unsigned FRAME_W = $bits(frame_cfg_t);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD} rx_state_e;

  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  function automatic logic [7:0] data_mask(input logic [1:0] code);
    return 8'hFF >> (2'd3 - code);
  endfunction
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the counter safe when the divisor shrinks mid-count
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         one_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign dout_o  = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = one_i ? !empty_o : (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       even_i,
  input  logic       stop2_i,
  input  logic       have_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       active_o,
  output logic       done_o,
  output logic       line_o
);
  logic        active_q;
  logic [11:0] sh_q;
  logic [3:0]  left_q, tcnt_q;
  logic [11:0] frm;
  logic [3:0]  nd, nbits;
  logic [7:0]  dm;
  logic        start;

  assign start    = en_i && have_i && !active_q && tick_i;
  assign pop_o    = start;
  assign active_o = active_q;
  assign line_o   = active_q ? sh_q[0] : 1'b1;
  assign done_o   = active_q && tick_i && (tcnt_q == 4'd15) && (left_q == 4'd1);

  always_comb begin
    nd    = data_bits(wlen_i);
    dm    = data_i & data_mask(wlen_i);
    nbits = 4'd2 + nd + 4'(par_en_i) + 4'(stop2_i);
    frm   = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(nd)) frm[i+1] = dm[i];
    end
    if (par_en_i) frm[nd + 4'd1] = (^dm) ^ ~even_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sh_q     <= '1;
      left_q   <= '0;
      tcnt_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      sh_q     <= frm;
      left_q   <= nbits;
      tcnt_q   <= '0;
    end else if (active_q && tick_i) begin
      tcnt_q <= tcnt_q + 1'b1;
      if (tcnt_q == 4'd15) begin
        sh_q   <= {1'b1, sh_q[11:1]};
        left_q <= left_q - 1'b1;
        if (left_q == 4'd1) active_q <= 1'b0;
      end
    end
  end

  assert_start_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (line_o == 1'b0));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       even_i,
  input  logic       rxd_i,
  output logic       push_o,
  output logic [9:0] word_o
);
  rx_state_e  state_q;
  logic [3:0] tcnt_q, nd;
  logic [2:0] idx_q;
  logic [7:0] dat_q;
  logic       perr_q;
  logic       mid;

  assign nd  = data_bits(wlen_i);
  assign mid = tick_i && (tcnt_q == 4'd15);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
      dat_q   <= '0;
      perr_q  <= 1'b0;
      push_o  <= 1'b0;
      word_o  <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i && state_q != RX_IDLE) tcnt_q <= tcnt_q + 1'b1;
      case (state_q)
        RX_IDLE: if (tick_i && en_i && !rxd_i) begin
          state_q <= RX_START;
          tcnt_q  <= '0;
        end
        RX_START: if (tick_i && tcnt_q == 4'd7) begin
          // re-check at mid start bit to reject glitches
          state_q <= rxd_i ? RX_IDLE : RX_DATA;
          tcnt_q  <= '0;
          idx_q   <= '0;
          dat_q   <= '0;
          perr_q  <= 1'b0;
        end
        RX_DATA: if (mid) begin
          dat_q[idx_q] <= rxd_i;
          idx_q        <= idx_q + 1'b1;
          if ({1'b0, idx_q} == nd - 4'd1) state_q <= par_en_i ? RX_PAR : RX_STOP;
        end
        RX_PAR: if (mid) begin
          perr_q  <= rxd_i ^ (^dat_q) ^ ~even_i;
          state_q <= RX_STOP;
        end
        RX_STOP: if (mid) begin
          push_o  <= 1'b1;
          word_o  <= {perr_q, !rxd_i, dat_q};
          state_q <= rxd_i ? RX_IDLE : RX_HOLD;
        end
        RX_HOLD: if (rxd_i) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_core.sv
module uart_core
  import uart_pkg::*;
#(
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        wr_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        txd_o,
  input  logic        rxd_i,
  input  logic        cts_i,
  input  logic        dsr_i,
  input  logic        dcd_i
);
  frame_cfg_t       cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       port_q;
  logic [2:0]       imask_q, istat_q, iset, iclr;
  logic             ovr_q;
  logic [1:0]       rxd_s_q;
  logic [2:0]       m_s1_q, m_s2_q, m_prev_q;
  logic             m_chg;
  logic             wr_en, rd_en, tick;
  logic             tx_push, tx_pop, tx_empty, tx_full, tx_active, tx_done, tx_line;
  logic [7:0]       tx_dout;
  logic             rx_push, rx_pop, rx_empty, rx_full, rx_acc;
  logic [9:0]       rx_word, rx_dout;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign wr_en   = sel_i && wr_i;
  assign rd_en   = sel_i && !wr_i;
  assign tx_push = wr_en && (addr_i == OFS_DATA) && !tx_full;
  assign rx_pop  = rd_en && (addr_i == OFS_DATA) && !rx_empty;
  assign rx_acc  = rx_push && !rx_full;
  assign m_chg   = (m_s2_q != m_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_s_q  <= 2'b11;
      m_s1_q   <= '0;
      m_s2_q   <= '0;
      m_prev_q <= '0;
    end else begin
      rxd_s_q  <= {rxd_s_q[0], rxd_i};
      m_s1_q   <= {dcd_i, dsr_i, cts_i};
      m_s2_q   <= m_s1_q;
      m_prev_q <= m_s2_q;
    end
  end

  uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .div_i(div_q), .tick_o(tick)
  );

  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .one_i(!cfg_q.fifo_en), .push_i(tx_push), .din_i(wdata_i[7:0]),
    .pop_i(tx_pop), .dout_o(tx_dout), .empty_o(tx_empty), .full_o(tx_full)
  );

  uart_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(port_q[0]), .wlen_i(cfg_q.wlen),
    .par_en_i(cfg_q.par_en), .even_i(cfg_q.even), .stop2_i(cfg_q.stop2),
    .have_i(!tx_empty), .data_i(tx_dout), .pop_o(tx_pop), .active_o(tx_active),
    .done_o(tx_done), .line_o(tx_line)
  );

  uart_rx u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(port_q[0]), .wlen_i(cfg_q.wlen),
    .par_en_i(cfg_q.par_en), .even_i(cfg_q.even), .rxd_i(rxd_s_q[1]),
    .push_o(rx_push), .word_o(rx_word)
  );

  uart_fifo #(.W(10), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .one_i(!cfg_q.fifo_en), .push_i(rx_acc), .din_i(rx_word),
    .pop_i(rx_pop), .dout_o(rx_dout), .empty_o(rx_empty), .full_o(rx_full)
  );

  assign iset = {m_chg, tx_done && tx_empty, rx_acc};
  assign iclr = (wr_en && addr_i == OFS_ICLR) ? wdata_i[2:0] : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      div_q   <= '0;
      port_q  <= '0;
      imask_q <= '0;
      istat_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr_i)
          OFS_FRAME: cfg_q   <= frame_cfg_t'(wdata_i[FRAME_W-1:0]);
          OFS_DIV:   div_q   <= wdata_i[DIV_W-1:0];
          OFS_PORT:  port_q  <= wdata_i[1:0];
          OFS_IMASK: imask_q <= wdata_i[2:0];
          default: ;
        endcase
      end
      istat_q <= (istat_q & ~iclr) | iset;
      if (rx_pop) ovr_q <= 1'b0;
      if (rx_push && rx_full) ovr_q <= 1'b1;
    end
  end

  assign irq_o = |(istat_q & imask_q);
  assign txd_o = cfg_q.brk ? 1'b0 : tx_line;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_DATA:  rdata_o[10:0]      = {ovr_q, rx_dout};
      OFS_FRAME: rdata_o[FRAME_W-1:0] = cfg_q;
      OFS_DIV:   rdata_o[DIV_W-1:0] = div_q;
      OFS_PORT:  rdata_o[1:0]       = port_q;
      OFS_FLAG:  rdata_o[5:0]       = {tx_full, rx_empty, tx_active || !tx_empty, m_s2_q};
      OFS_ISTAT: rdata_o[2:0]       = istat_q;
      OFS_IMASK: rdata_o[2:0]       = imask_q;
      default:   rdata_o            = '0;
    endcase
  end

  assert_tx_hold_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_q[0] |-> !tx_pop);
  assert_overrun_mark_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full) |=> ovr_q);
  assert_irq_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == OFS_ICLR && wdata_i[2:0] == 3'b111 && !rx_push && !tx_done && !m_chg)
      |=> (istat_q == 3'b000));
endmodule

// File: tb/tb_uart_core.sv
`timescale 1ns/1ps
module tb_uart_core;
  localparam int BIT_CYC = 32;  // divisor 1 -> 16 * 2

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, txd, rxd;
  logic        rxd_drv = 1'b1, loop_en = 1'b0;
  logic        cts = 1'b0, dsr = 1'b0, dcd = 1'b0;
  int          total = 0, bad = 0;

  assign rxd = loop_en ? txd : rxd_drv;
  always #2.5 clk = ~clk;

  uart_core dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .txd_o(txd), .rxd_i(rxd), .cts_i(cts), .dsr_i(dsr), .dcd_i(dcd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic set_frame(input logic [1:0] wl, input logic pen, input logic ev,
                           input logic st2, input logic fen, input logic brk);
    bus_wr(5'h04, {25'b0, wl, fen, st2, ev, pen, brk});
  endtask

  function automatic logic [11:0] exp_bits(input logic [7:0] d, input logic [1:0] wl,
                                           input logic pen, input logic ev);
    logic [11:0] b;
    logic [7:0]  dm;
    int          nd;
    nd = 5 + int'(wl);
    dm = d & 8'((1 << nd) - 1);
    b = '1;
    b[0] = 1'b0;
    for (int i = 0; i < nd; i++) b[1+i] = dm[i];
    if (pen) b[1+nd] = ev ? ^dm : ~^dm;
    return b;
  endfunction

  function automatic int exp_len(input logic [1:0] wl, input logic pen, input logic st2);
    return 7 + int'(wl) + int'(pen) + int'(st2);
  endfunction

  task automatic capture(input int n, output logic [11:0] bits);
    bits = '1;
    @(negedge txd);
    repeat (BIT_CYC / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      if (i < n - 1) repeat (BIT_CYC) @(negedge clk);
    end
  endtask

  task automatic send(input logic [11:0] bits, input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd_drv = bits[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    rxd_drv = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [11:0] got, exp;
    logic [11:0] msk;
    int          n, glitch;
    logic [1:0]  wl;
    logic        pen, ev, st2;
    logic [7:0]  d;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd idle", 32'(txd), 32'h1);
    chk("R1 irq", 32'(irq), 32'h0);
    bus_rd(5'h10, v); chk("R1 flags", v, 32'h10);
    bus_rd(5'h04, v); chk("R1 frame", v, 32'h0);
    bus_rd(5'h08, v); chk("R1 divisor", v, 32'h0);
    bus_rd(5'h18, v); chk("R1 mask", v, 32'h0);
    bus_rd(5'h14, v); chk("R1 status", v, 32'h0);

    bus_wr(5'h08, 32'h1);
    bus_wr(5'h0C, 32'h3);
    bus_wr(5'h18, 32'h5);
    set_frame(2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    bus_rd(5'h08, v); chk("R11 divisor", v, 32'h1);
    bus_rd(5'h0C, v); chk("R11 port", v, 32'h3);
    bus_rd(5'h18, v); chk("R11 mask", v, 32'h5);
    bus_rd(5'h04, v); chk("R11 frame", v, 32'h5A);
    bus_wr(5'h18, 32'h0);
    bus_wr(5'h0C, 32'h1);

    // random loopback: line bits and returned byte
    loop_en = 1'b1;
    for (int it = 0; it < 12; it++) begin
      wl = 2'($urandom); pen = 1'($urandom); ev = 1'($urandom); st2 = 1'($urandom);
      d  = 8'($urandom);
      set_frame(wl, pen, ev, st2, 1'b0, 1'b0);
      n   = exp_len(wl, pen, st2);
      msk = 12'((1 << n) - 1);
      exp = exp_bits(d, wl, pen, ev);
      fork
        capture(n, got);
        bus_wr(5'h00, {24'b0, d});
      join
      chk("R2 R4 line frame", 32'(got & msk), 32'(exp & msk));
      repeat (20) @(negedge clk);
      bus_rd(5'h00, v);
      chk("R3 R6 loopback byte", v, 32'(d & 8'((1 << (5 + int'(wl))) - 1)));
    end

    // 5-bit word with upper bits set
    set_frame(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    fork
      capture(7, got);
      bus_wr(5'h00, 32'hFF);
    join
    chk("R3 five-bit line", 32'(got & 12'h7F), 32'h7E);
    repeat (20) @(negedge clk);
    bus_rd(5'h00, v); chk("R3 five-bit read", v, 32'h1F);
    loop_en = 1'b0;

    // parity error mark
    set_frame(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    exp = exp_bits(8'hA5, 2'b11, 1'b1, 1'b1);
    exp[9] = ~exp[9];
    send(exp, 11);
    bus_rd(5'h00, v); chk("R6 parity error bit9", v, 32'h2A5);

    // framing error mark
    set_frame(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    exp = exp_bits(8'h3C, 2'b11, 1'b0, 1'b0);
    exp[9] = 1'b0;
    send(exp, 10);
    bus_rd(5'h00, v); chk("R6 frame error bit8", v, 32'h13C);

    // overrun with one-entry buffer
    bus_wr(5'h1C, 32'h7);
    send(exp_bits(8'h11, 2'b11, 1'b0, 1'b0), 10);
    bus_rd(5'h14, v); chk("R9 rx status", v & 32'h1, 32'h1);
    bus_rd(5'h10, v); chk("R8 rx not empty", v & 32'h10, 32'h0);
    send(exp_bits(8'h22, 2'b11, 1'b0, 1'b0), 10);
    bus_rd(5'h00, v); chk("R7 overrun bit10", v, 32'h411);
    bus_rd(5'h10, v); chk("R7 second byte dropped", v & 32'h10, 32'h10);

    // deep buffer keeps order
    set_frame(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send(exp_bits(8'h33, 2'b11, 1'b0, 1'b0), 10);
    send(exp_bits(8'h44, 2'b11, 1'b0, 1'b0), 10);
    send(exp_bits(8'h55, 2'b11, 1'b0, 1'b0), 10);
    bus_rd(5'h00, v); chk("R7 fifo first", v, 32'h33);
    bus_rd(5'h00, v); chk("R7 fifo second", v, 32'h44);
    bus_rd(5'h00, v); chk("R7 fifo third", v, 32'h55);
    bus_rd(5'h10, v); chk("R7 fifo drained", v & 32'h10, 32'h10);

    // break
    set_frame(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk("R5 break low", 32'(txd), 32'h0);
    set_frame(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R5 break released", 32'(txd), 32'h1);

    // busy span
    fork
      capture(10, got);
      bus_wr(5'h00, 32'h5A);
    join
    bus_rd(5'h10, v); chk("R8 busy in stop bit", v & 32'h8, 32'h8);
    repeat (20) @(negedge clk);
    bus_rd(5'h10, v); chk("R8 busy cleared", v & 32'h8, 32'h0);

    // transmit full, tx status, masking
    bus_wr(5'h1C, 32'h7);
    bus_wr(5'h00, 32'h01);
    bus_wr(5'h00, 32'h02);
    bus_rd(5'h10, v); chk("R8 tx full and busy", v & 32'h28, 32'h28);
    bus_rd(5'h14, v); chk("R9 no tx status while pending", v & 32'h2, 32'h0);
    repeat (2 * 10 * BIT_CYC + 100) @(negedge clk);
    bus_rd(5'h10, v); chk("R8 tx drained", v & 32'h28, 32'h0);
    bus_rd(5'h14, v); chk("R9 tx status", v & 32'h2, 32'h2);
    chk("R9 masked irq", 32'(irq), 32'h0);
    bus_wr(5'h18, 32'h2);
    @(negedge clk);
    chk("R9 irq unmasked", 32'(irq), 32'h1);
    bus_wr(5'h1C, 32'h2);
    bus_rd(5'h14, v); chk("R9 tx status cleared", v, 32'h0);
    chk("R9 irq after clear", 32'(irq), 32'h0);

    // modem inputs
    bus_wr(5'h18, 32'h4);
    cts = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(5'h10, v); chk("R8 cts flag", v & 32'h7, 32'h1);
    bus_rd(5'h14, v); chk("R9 modem status", v, 32'h4);
    chk("R9 modem irq", 32'(irq), 32'h1);
    bus_wr(5'h1C, 32'h4);
    @(negedge clk);
    chk("R9 modem irq cleared", 32'(irq), 32'h0);
    dsr = 1'b1; dcd = 1'b1; cts = 1'b0;
    repeat (4) @(negedge clk);
    bus_rd(5'h10, v); chk("R8 dsr dcd flags", v & 32'h7, 32'h6);
    bus_wr(5'h1C, 32'h7);
    bus_wr(5'h18, 32'h0);

    // disabled port
    bus_wr(5'h0C, 32'h0);
    bus_wr(5'h00, 32'h77);
    glitch = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (txd !== 1'b1) glitch++;
    end
    chk("R10 no start when disabled", 32'(glitch), 32'h0);
    bus_rd(5'h10, v); chk("R10 byte waiting", v & 32'h8, 32'h8);
    fork
      capture(10, got);
      bus_wr(5'h0C, 32'h1);
    join
    chk("R10 sends after enable", 32'(got & 12'h3FF), 32'(exp_bits(8'h77, 2'b11, 1'b0, 1'b0) & 12'h3FF));
    repeat (40) @(negedge clk);
    bus_wr(5'h1C, 32'h7);
    bus_wr(5'h0C, 32'h0);
    send(exp_bits(8'h66, 2'b11, 1'b0, 1'b0), 10);
    bus_rd(5'h10, v); chk("R10 rx ignored", v & 32'h10, 32'h10);
    bus_rd(5'h14, v); chk("R10 no rx status", v & 32'h1, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule